// File: doc/BRIEF.md
# SPI Opcode Bridge to Byte Port and Board Outputs

This block is an SPI target for a host controller. Each transaction opens with an 8-bit opcode sent single-bit. The opcode selects one of these actions: load an 8-bit board-output register, pass write bytes to a downstream byte sink, fetch bytes from a downstream byte source and return them on MISO, or set a separate indicator output. The downstream side is a pair of byte streams with valid/ready handshakes. The board outputs and the indicator are plain level pins.

All SPI pins are brought into the system clock domain through synchronisers. SCK edges are then found by comparing samples, so the system clock must be well above the SCK rate; at least eight system cycles per SCK half period is assumed. Write data after a write opcode arrives two bits per SCK rise. A write transaction always ends with one idle byte that is never forwarded. Read opcodes insert one or four idle bytes before data. During those idle bytes the block prefetches the first data byte.

Back-pressure rules. On the write stream, a byte stays on the data pins with valid high until the sink takes it with ready. The sink must take each byte within four SCK periods, because a later byte then replaces it. On the read stream, the block raises ready to request one byte, one byte time before that byte is shifted out. It drops ready for as long as it holds a byte. A source that has not delivered by the time the byte is needed makes the block shift out 0x00.

Top module: `spi_cmd_bridge`

## Requirements
- R1: The SPI bus works in mode 0 (SCK idles low). The target samples on the SCK rise and changes MISO after the SCK fall. Single-bit bytes travel most significant bit first on `spi_d0_i`, and a byte is complete after 8 rises while selected.
- R2: After reset, `cfg_o` is 0x1F: bit 0 is the active-low chip enable, bits 1 to 4 are the four active-low LEDs, and bits 5 to 7 are general outputs at 0. `led5_on_o` is 0, MISO is 0, and neither stream handshake signal is high.
- R3: Opcode 0x09 makes every later complete byte of the transaction load `cfg_o`, so the last complete byte before deselect remains. A partial byte changes nothing.
- R4: Opcode 0x0C sets `led5_on_o` to 1 and opcode 0x0D clears it. Further bytes in the same transaction are ignored.
- R5: After opcode 0x08, each byte is taken two bits per rise over four rises, most significant pair first. `spi_d1_i` carries the higher bit of each pair. Data bytes reach `wr_data_o` in the order received.
- R6: The last complete byte of a write transaction is the trailing idle byte and is never forwarded. A partial byte is discarded.
- R7: `wr_data_o` holds steady while `wr_valid_o` is high and `wr_ready_i` is low.
- R8: After opcode 0x0A, MISO is 0 for one idle byte. Each following byte is a byte taken from the read stream, shifted out most significant bit first.
- R9: After opcode 0x0B, MISO is 0 for four idle bytes before read data begins.
- R10: `rd_ready_o` rises no later than the start of the byte before a data byte. It is low in the cycle after a read handshake. A data byte with no delivered source byte is sent as 0x00.
- R11: An opcode outside 0x08 to 0x0D leaves `cfg_o`, `led5_on_o` and the write stream untouched, and MISO stays 0 until deselect.
- R12: Raising `spi_cs_n_i` aborts the command and returns to opcode decode. Once deselected, MISO is 0 and neither `cfg_o` nor `led5_on_o` nor a new write byte changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| spi_sck_i | input | 1 | SPI clock from host |
| spi_cs_n_i | input | 1 | active-low target select |
| spi_d0_i | input | 1 | host data line, also low bit of a dual pair |
| spi_d1_i | input | 1 | second host data line, high bit of a dual pair |
| spi_miso_o | output | 1 | target data to host |
| wr_valid_o | output | 1 | write byte available |
| wr_ready_i | input | 1 | sink accepts write byte |
| wr_data_o | output | 8 | write byte |
| rd_ready_o | output | 1 | request for one read byte |
| rd_valid_i | input | 1 | source offers read byte |
| rd_data_i | input | 8 | read byte |
| cfg_o | output | 8 | board output register |
| led5_on_o | output | 1 | indicator, 1 = on |

## Verification
The board register is loaded with a stride through all 256 values, which exposes bit order and dropped bits. Multi-byte and truncated loads separate last-complete-byte behaviour from partial-byte leakage. Write transactions of one to six bytes run against a sink that refuses one cycle in three; they test the dual pair order and the one-byte holdback that drops the idle byte, and a truncated write shows that the last complete byte is the one dropped. Read transactions of several lengths, with one and four idle bytes, compare MISO against an arithmetic source sequence; a run with the source silent shows the zero fill, and unknown opcodes show that nothing moves.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  typedef enum logic [2:0] {
    ST_OPCODE,
    ST_CFG,
    ST_WRITE,
    ST_READ,
    ST_SKIP
  } seq_state_t;

  localparam logic [7:0] OP_WRITE   = 8'h08;
  localparam logic [7:0] OP_CFG     = 8'h09;
  localparam logic [7:0] OP_READ    = 8'h0A;
  localparam logic [7:0] OP_READ_F  = 8'h0B;
  localparam logic [7:0] OP_LED_ON  = 8'h0C;
  localparam logic [7:0] OP_LED_OFF = 8'h0D;

  // pin order inside the synchroniser word
  localparam int PIN_SCK = 0;
  localparam int PIN_CSN = 1;
  localparam int PIN_D0  = 2;
  localparam int PIN_D1  = 3;
  localparam int NUM_PINS = 4;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync
  import spi_bridge_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic d0_i,
  input  logic d1_i,
  output logic sel_o,
  output logic rise_o,
  output logic fall_o,
  output logic d0_o,
  output logic d1_o
);

  localparam logic [NUM_PINS-1:0] IDLE_WORD = NUM_PINS'(1) << PIN_CSN;

  logic [STAGES-1:0][NUM_PINS-1:0] chain_q;
  logic [NUM_PINS-1:0] pins;
  logic [NUM_PINS-1:0] last;
  logic                sck_prev;

  always_comb begin
    pins          = '0;
    pins[PIN_SCK] = sck_i;
    pins[PIN_CSN] = cs_n_i;
    pins[PIN_D0]  = d0_i;
    pins[PIN_D1]  = d1_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain_q[s] <= IDLE_WORD;
      sck_prev <= 1'b0;
    end else begin
      chain_q[0] <= pins;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
      sck_prev <= chain_q[STAGES-1][PIN_SCK];
    end
  end

  assign last   = chain_q[STAGES-1];
  assign sel_o  = !last[PIN_CSN];
  assign rise_o = sel_o &&  last[PIN_SCK] && !sck_prev;
  assign fall_o = sel_o && !last[PIN_SCK] &&  sck_prev;
  assign d0_o   = last[PIN_D0];
  assign d1_o   = last[PIN_D1];

endmodule

// File: rtl/spi_rx_assembler.sv
module spi_rx_assembler #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         rise_i,
  input  logic         dual_i,
  input  logic         d0_i,
  input  logic         d1_i,
  output logic         done_o,
  output logic [W-1:0] data_o,
  output logic         boundary_o
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nxt;
  logic [W-1:0]  sh_q;
  logic [W-1:0]  sh_nxt;

  always_comb begin
    if (dual_i) begin
      sh_nxt  = {sh_q[W-3:0], d1_i, d0_i};
      cnt_nxt = cnt_q + CW'(2);
    end else begin
      sh_nxt  = {sh_q[W-2:0], d0_i};
      cnt_nxt = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      done_o <= 1'b0;
      data_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!sel_i) begin
        cnt_q <= '0;
        sh_q  <= '0;
      end else if (rise_i) begin
        sh_q <= sh_nxt;
        if (cnt_nxt >= CW'(W)) begin
          cnt_q  <= '0;
          done_o <= 1'b1;
          data_o <= sh_nxt;
        end else begin
          cnt_q <= cnt_nxt;
        end
      end
    end
  end

  assign boundary_o = (cnt_q == '0);

endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         fall_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         miso_o
);

  logic [W-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (!sel_i) begin
      sh_q <= '0;
    end else if (fall_i) begin
      if (load_i) sh_q <= load_val_i;
      else        sh_q <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign miso_o = sh_q[W-1];

endmodule

// File: rtl/spi_cmd_sequencer.sv
module spi_cmd_sequencer
  import spi_bridge_pkg::*;
#(
  parameter int             W         = 8,
  parameter logic [W-1:0]   CFG_RESET = 8'h1F,
  parameter int             NAND_IDLE = 1,
  parameter int             FAST_IDLE = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic         byte_done_i,
  input  logic [W-1:0] byte_i,
  input  logic         load_i,
  output logic         dual_o,
  output logic [W-1:0] tx_byte_o,
  output logic [W-1:0] cfg_o,
  output logic         led_o,
  output logic         wr_valid_o,
  input  logic         wr_ready_i,
  output logic [W-1:0] wr_data_o,
  output logic         rd_ready_o,
  input  logic         rd_valid_i,
  input  logic [W-1:0] rd_data_i
);

  localparam int IMAX = (FAST_IDLE > NAND_IDLE) ? FAST_IDLE : NAND_IDLE;
  localparam int IW   = $clog2(IMAX + 1);

  seq_state_t   state_q;
  logic [IW-1:0] idle_q;
  logic [W-1:0]  pend_q;
  logic          pend_v_q;
  logic [W-1:0]  hold_q;
  logic          hold_v_q;
  logic          data_phase;

  assign data_phase = (state_q == ST_READ) && (idle_q == '0);
  assign tx_byte_o  = (data_phase && hold_v_q) ? hold_q : '0;
  assign rd_ready_o = sel_i && (state_q == ST_READ) &&
                      (idle_q <= IW'(1)) && !hold_v_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_OPCODE;
      idle_q     <= '0;
      dual_o     <= 1'b0;
      cfg_o      <= CFG_RESET;
      led_o      <= 1'b0;
      pend_q     <= '0;
      pend_v_q   <= 1'b0;
      hold_q     <= '0;
      hold_v_q   <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
    end else begin
      // downstream handshakes
      if (wr_valid_o && wr_ready_i) wr_valid_o <= 1'b0;
      if (load_i && data_phase) hold_v_q <= 1'b0;
      if (rd_ready_o && rd_valid_i) begin
        hold_q   <= rd_data_i;
        hold_v_q <= 1'b1;
      end

      if (!sel_i) begin
        state_q  <= ST_OPCODE;
        idle_q   <= '0;
        dual_o   <= 1'b0;
        pend_v_q <= 1'b0;
        hold_v_q <= 1'b0;
      end else if (byte_done_i) begin
        unique case (state_q)
          ST_OPCODE: begin
            unique case (byte_i)
              OP_CFG:    state_q <= ST_CFG;
              OP_WRITE: begin
                state_q <= ST_WRITE;
                dual_o  <= 1'b1;
              end
              OP_READ: begin
                state_q <= ST_READ;
                idle_q  <= IW'(NAND_IDLE);
              end
              OP_READ_F: begin
                state_q <= ST_READ;
                idle_q  <= IW'(FAST_IDLE);
              end
              OP_LED_ON: begin
                led_o   <= 1'b1;
                state_q <= ST_SKIP;
              end
              OP_LED_OFF: begin
                led_o   <= 1'b0;
                state_q <= ST_SKIP;
              end
              default:   state_q <= ST_SKIP;
            endcase
          end
          ST_CFG: cfg_o <= byte_i;
          ST_WRITE: begin
            // the newest byte may be the trailing idle byte: hold it back
            if (pend_v_q) begin
              wr_data_o  <= pend_q;
              wr_valid_o <= 1'b1;
            end
            pend_q   <= byte_i;
            pend_v_q <= 1'b1;
          end
          ST_READ: begin
            if (idle_q != '0) idle_q <= idle_q - IW'(1);
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_cmd_bridge.sv
module spi_cmd_bridge #(
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] CFG_RESET   = 8'h1F,
  parameter int           NAND_IDLE   = 1,
  parameter int           FAST_IDLE   = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         spi_sck_i,
  input  logic         spi_cs_n_i,
  input  logic         spi_d0_i,
  input  logic         spi_d1_i,
  output logic         spi_miso_o,
  output logic         wr_valid_o,
  input  logic         wr_ready_i,
  output logic [W-1:0] wr_data_o,
  output logic         rd_ready_o,
  input  logic         rd_valid_i,
  input  logic [W-1:0] rd_data_i,
  output logic [W-1:0] cfg_o,
  output logic         led5_on_o
);

  logic         sel, rise, fall, d0, d1;
  logic         dual, byte_done, boundary, load;
  logic [W-1:0] rx_byte, tx_byte;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_i  (spi_sck_i),
    .cs_n_i (spi_cs_n_i),
    .d0_i   (spi_d0_i),
    .d1_i   (spi_d1_i),
    .sel_o  (sel),
    .rise_o (rise),
    .fall_o (fall),
    .d0_o   (d0),
    .d1_o   (d1)
  );

  spi_rx_assembler #(.W(W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel),
    .rise_i     (rise),
    .dual_i     (dual),
    .d0_i       (d0),
    .d1_i       (d1),
    .done_o     (byte_done),
    .data_o     (rx_byte),
    .boundary_o (boundary)
  );

  // a fall with no bits pending starts the next outgoing byte
  assign load = fall && boundary;

  spi_tx_shifter #(.W(W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel),
    .fall_i     (fall),
    .load_i     (boundary),
    .load_val_i (tx_byte),
    .miso_o     (spi_miso_o)
  );

  spi_cmd_sequencer #(
    .W         (W),
    .CFG_RESET (CFG_RESET),
    .NAND_IDLE (NAND_IDLE),
    .FAST_IDLE (FAST_IDLE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_i       (sel),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .load_i      (load),
    .dual_o      (dual),
    .tx_byte_o   (tx_byte),
    .cfg_o       (cfg_o),
    .led_o       (led5_on_o),
    .wr_valid_o  (wr_valid_o),
    .wr_ready_i  (wr_ready_i),
    .wr_data_o   (wr_data_o),
    .rd_ready_o  (rd_ready_o),
    .rd_valid_i  (rd_valid_i),
    .rd_data_i   (rd_data_i)
  );

endmodule

// File: rtl/spi_cmd_bridge_checker.sv
module spi_cmd_bridge_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         spi_cs_n_i,
  input logic         spi_miso_o,
  input logic [W-1:0] cfg_o,
  input logic         led5_on_o,
  input logic         wr_valid_o,
  input logic         wr_ready_i,
  input logic [W-1:0] wr_data_o,
  input logic         rd_valid_i,
  input logic         rd_ready_o
);

  // cycles the select pin has been high, saturating
  logic [2:0] desel_cnt;
  logic       quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                desel_cnt <= '0;
    else if (!spi_cs_n_i)      desel_cnt <= '0;
    else if (desel_cnt != 3'd7) desel_cnt <= desel_cnt + 3'd1;
  end

  assign quiet = (desel_cnt >= 3'd6);

  p_wr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o));

  p_rd_gap_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_i && rd_ready_o |=> !rd_ready_o);

  p_miso_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !spi_miso_o);

  p_cfg_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> $stable(cfg_o));

  p_led_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> $stable(led5_on_o));

  p_no_write_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |-> !$rose(wr_valid_o));

endmodule

bind spi_cmd_bridge spi_cmd_bridge_checker #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .spi_cs_n_i (spi_cs_n_i),
  .spi_miso_o (spi_miso_o),
  .cfg_o      (cfg_o),
  .led5_on_o  (led5_on_o),
  .wr_valid_o (wr_valid_o),
  .wr_ready_i (wr_ready_i),
  .wr_data_o  (wr_data_o),
  .rd_valid_i (rd_valid_i),
  .rd_ready_o (rd_ready_o)
);

// File: tb/spi_cmd_bridge_test.sv
module spi_cmd_bridge_test;

  localparam int CLK_P = 10;
  localparam int HALF  = 8 * CLK_P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sck = 1'b0, cs_n = 1'b1, d0 = 1'b0, d1 = 1'b0;
  logic       miso;
  logic       wr_valid, wr_ready, rd_ready, rd_valid, led;
  logic [7:0] wr_data, rd_data, cfg;

  int n_chk = 0, n_fail = 0;
  int tick = 0;
  int ridx = 0;
  bit rd_en = 1'b1;
  int nw = 0;
  logic [7:0] got [0:63];

  always #(CLK_P/2) clk = ~clk;

  spi_cmd_bridge uut (
    .clk(clk), .rst_n(rst_n),
    .spi_sck_i(sck), .spi_cs_n_i(cs_n), .spi_d0_i(d0), .spi_d1_i(d1),
    .spi_miso_o(miso),
    .wr_valid_o(wr_valid), .wr_ready_i(wr_ready), .wr_data_o(wr_data),
    .rd_ready_o(rd_ready), .rd_valid_i(rd_valid), .rd_data_i(rd_data),
    .cfg_o(cfg), .led5_on_o(led)
  );

  function automatic logic [7:0] rd_pat(int i);
    return 8'((i * 37) + 11);
  endfunction

  function automatic logic [7:0] wr_pat(int n, int k);
    return 8'((n * 29) + (k * 71) + 5);
  endfunction

  // downstream models
  always @(negedge clk) begin
    tick     <= tick + 1;
    wr_ready <= (tick % 3) != 0;
  end
  assign rd_valid = rd_en;
  assign rd_data  = rd_pat(ridx);

  always @(posedge clk) begin
    if (rd_valid && rd_ready) ridx <= ridx + 1;
    if (wr_valid && wr_ready) begin
      if (nw < 64) got[nw] <= wr_data;
      nw <= nw + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sel_on();
    cs_n = 1'b0;
    #(HALF);
  endtask

  task automatic sel_off();
    #(HALF);
    cs_n = 1'b1;
    #(HALF * 4);
  endtask

  task automatic byte_single(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      d0 = tx[i];
      #(HALF);
      sck = 1'b1;
      rx[i] = miso;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic byte_dual(input logic [7:0] tx);
    for (int p = 3; p >= 0; p--) begin
      d1 = tx[2*p+1];
      d0 = tx[2*p];
      #(HALF);
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic bits_single(input int k);
    for (int i = 0; i < k; i++) begin
      d0 = 1'b1;
      #(HALF);
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic do_write(input int n);
    logic [7:0] rx;
    int base;
    base = nw;
    sel_on();
    byte_single(8'h08, rx);
    for (int k = 0; k < n; k++) byte_dual(wr_pat(n, k));
    byte_dual(8'hFF);
    sel_off();
    check("R6 write count", nw - base, n);
    for (int k = 0; k < n; k++)
      check("R5 write byte", got[base + k], wr_pat(n, k));
  endtask

  task automatic do_read(input logic [7:0] op, input int idles, input int n,
                         input bit live);
    logic [7:0] rx;
    int i0;
    i0 = ridx;
    sel_on();
    byte_single(op, rx);
    check("R8 miso during opcode", rx, 0);
    for (int k = 0; k < idles; k++) begin
      byte_single(8'h00, rx);
      check(idles == 1 ? "R8 idle byte" : "R9 idle byte", rx, 0);
    end
    for (int k = 0; k < n; k++) begin
      byte_single(8'h00, rx);
      if (live) check(idles == 1 ? "R8 read data" : "R9 read data", rx, rd_pat(i0 + k));
      else      check("R10 empty source", rx, 0);
    end
    sel_off();
    check("R12 miso after deselect", miso, 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2 reset state
    check("R2 cfg reset", cfg, 8'h1F);
    check("R2 led reset", led, 0);
    check("R2 miso reset", miso, 0);
    check("R2 wr_valid reset", wr_valid, 0);
    check("R2 rd_ready reset", rd_ready, 0);

    // R1 R3 stride over all values
    for (int v = 0; v < 256; v += 3) begin
      sel_on();
      byte_single(8'h09, rx);
      byte_single(8'(v), rx);
      sel_off();
      check("R1 R3 cfg load", cfg, v);
    end

    // R3 last complete byte wins
    sel_on();
    byte_single(8'h09, rx);
    byte_single(8'hA5, rx);
    byte_single(8'h3C, rx);
    byte_single(8'hC3, rx);
    sel_off();
    check("R3 last byte", cfg, 8'hC3);

    // R3 R12 partial byte discarded
    sel_on();
    byte_single(8'h09, rx);
    byte_single(8'h5A, rx);
    bits_single(5);
    sel_off();
    check("R3 R12 partial cfg", cfg, 8'h5A);

    // R4 indicator
    sel_on(); byte_single(8'h0C, rx); sel_off();
    check("R4 led on", led, 1);
    sel_on(); byte_single(8'h0C, rx); byte_single(8'h0D, rx); sel_off();
    check("R4 trailing ignored", led, 1);
    check("R4 cfg untouched", cfg, 8'h5A);
    sel_on(); byte_single(8'h0D, rx); byte_single(8'hFF, rx); sel_off();
    check("R4 led off", led, 0);

    // R5 R6 R7 writes of several lengths against a stalling sink
    for (int n = 1; n <= 6; n++) do_write(n);

    // R6 R12 aborted write: last complete byte dropped
    base = nw;
    sel_on();
    byte_single(8'h08, rx);
    byte_dual(8'h96);
    byte_dual(8'h69);
    d1 = 1'b1; d0 = 1'b0;
    #(HALF); sck = 1'b1; #(HALF); sck = 1'b0;
    sel_off();
    check("R6 abort count", nw - base, 1);
    check("R6 abort byte", got[base], 8'h96);

    // R8 R10 reads
    for (int n = 1; n <= 5; n++) do_read(8'h0A, 1, n, 1'b1);
    // R9 fast read
    do_read(8'h0B, 4, 3, 1'b1);
    // R10 silent source
    rd_en = 1'b0;
    do_read(8'h0A, 1, 2, 1'b0);
    rd_en = 1'b1;
    do_read(8'h0B, 4, 2, 1'b1);

    // R11 unknown opcodes
    for (int op = 0; op < 2; op++) begin
      base = nw;
      sel_on();
      byte_single(op == 0 ? 8'h5E : 8'h07, rx);
      for (int k = 0; k < 3; k++) begin
        byte_single(8'h0C, rx);
        check("R11 miso zero", rx, 0);
      end
      sel_off();
      check("R11 cfg kept", cfg, 8'h5A);
      check("R11 led kept", led, 0);
      check("R11 no write", nw - base, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule